// File: doc/BRIEF.md
# 8-bit Processor Load/Store Execution Unit

This block executes the data-movement instructions of a small 8-bit processor with a 16-bit address space. The decode stage hands it one operation at a time: an operation code, destination and source register selectors, and any immediate byte or word. The unit owns the seven byte registers (accumulator A plus B, C, D, E, H, L), the 16-bit stack pointer and the four-bit flag register. It performs register copies, immediate loads and memory transfers over a byte-wide request/ready bus, and it signals completion with a one-clock pulse.

Memory transfers address through the H:L pair (H is the high byte), optionally stepping that pair up or down by one after the transfer, or through the top page of memory (0xFF00 plus C, or plus an 8-bit immediate). One operation adds a sign-extended 8-bit offset to the stack pointer and places the sum in H:L; it is the only operation here that writes the flags. A machine cycle is four clocks: register-only operations take one, memory operations take two plus any wait the memory adds. A registered observation port lets the surrounding logic read any byte register.

Top module: `ldst_unit`

## Requirements
- R1: After reset, all byte registers, the stack pointer and flags read zero, and busy, done, mem_req and mem_we are low.
- R2: Code 0 copies register op_src into register op_dst for every one of the 7x7 pairings, self-copies included; register encoding is A=0, B=1, C=2, D=3, E=4, H=5, L=6.
- R3: Code 1 writes op_imm8 into register op_dst; code 2 writes op_imm16 into the pair chosen by op_dst[1:0] (0 B:C, 1 D:E, 2 H:L, 3 stack pointer), the high byte going to the first-named register.
- R4: Code 3 loads op_dst from address {H,L}; code 4 stores op_src to {H,L}; a store raises mem_we with mem_req and drives the byte on mem_wdata.
- R5: Codes 5 and 6 load A from {H,L}, codes 7 and 8 store A to {H,L}; codes 5 and 7 then add one to H:L, codes 6 and 8 subtract one, wrapping modulo 2^16, with the same latency as codes 3 and 4.
- R6: Codes 9 (load A) and 10 (store A) use address 0xFF00 plus C; codes 11 (load A) and 12 (store A) use 0xFF00 plus op_imm8.
- R7: Code 13 writes H:L with the stack pointer plus op_imm8 sign-extended to 16 bits; the stack pointer itself is not changed.
- R8: Code 13 sets flags {Z,N,H,C} on bits [3:0] to Z=0, N=0, H = carry out of bit 3 and C = carry out of bit 7 of the unsigned addition of the stack pointer's low byte and op_imm8.
- R9: Every operation other than code 13 leaves the flags unchanged, and the flags change only in the cycle that done is high.
- R10: An operation is accepted on a clock edge with op_valid high and busy low; done is a one-clock pulse that rises 4 clocks after acceptance for codes 0-2, 13-15. For codes 3-12, mem_req rises 4 clocks after acceptance and holds with stable address, direction and data until mem_ready is sampled; done then rises 8 clocks after acceptance, or on the edge that samples mem_ready if that comes later.
- R11: busy is high from the edge after acceptance up to the edge that raises done; op_valid seen while busy is ignored.
- R12: Codes 14 and 15 complete like a register operation and change no register, stack pointer or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present on the op_* inputs |
| op_code | input | 4 | Operation code |
| op_dst | input | 3 | Destination register or pair selector |
| op_src | input | 3 | Source register selector |
| op_imm8 | input | 8 | Immediate byte (data, high-page offset or signed offset) |
| op_imm16 | input | 16 | Immediate word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| flags | output | 4 | {Z,N,H,C} |
| obs_sel | input | 3 | Register to observe (0-6; 7 reads zero) |
| obs_data | output | 8 | Observed register, one clock after obs_sel |

## Verification
The assertions assume mem_ready is raised only while mem_req is high, that the register selectors stay within 0 to 6, and that the step forms (codes 5-8) are the only ones touching H:L and memory in the same operation. The bench's memory responder raises mem_ready only in cycles where it sees mem_req, after a chosen number of wait cycles from zero to beyond the machine cycle, and every operation it issues uses legal selectors. Operations sent while the unit is busy are sent on purpose, only to show that they are dropped.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int IDX_W = 3;
  localparam int NREG  = 7;

  // register selectors
  localparam logic [IDX_W-1:0] RSEL_A = 3'd0;
  localparam logic [IDX_W-1:0] RSEL_C = 3'd2;

  // pair selectors (second field of the 16-bit immediate load)
  localparam logic [1:0] PAIR_HL = 2'd2;
  localparam logic [1:0] PAIR_SP = 2'd3;

  // operation codes
  localparam logic [3:0] OP_MOV     = 4'd0;
  localparam logic [3:0] OP_IMM8    = 4'd1;
  localparam logic [3:0] OP_IMM16   = 4'd2;
  localparam logic [3:0] OP_LD_HL   = 4'd3;
  localparam logic [3:0] OP_ST_HL   = 4'd4;
  localparam logic [3:0] OP_LD_HLUP = 4'd5;
  localparam logic [3:0] OP_LD_HLDN = 4'd6;
  localparam logic [3:0] OP_ST_HLUP = 4'd7;
  localparam logic [3:0] OP_ST_HLDN = 4'd8;
  localparam logic [3:0] OP_LD_PGC  = 4'd9;
  localparam logic [3:0] OP_ST_PGC  = 4'd10;
  localparam logic [3:0] OP_LD_PGI  = 4'd11;
  localparam logic [3:0] OP_ST_PGI  = 4'd12;
  localparam logic [3:0] OP_SPOFS   = 4'd13;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_EXEC,
    SQ_MEM
  } seq_e;

  typedef enum logic [1:0] {
    AM_PAIR,
    AM_PAGE_C,
    AM_PAGE_IMM
  } amode_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  function automatic logic op_is_mem(input logic [3:0] op);
    return (op >= OP_LD_HL) && (op <= OP_ST_PGI);
  endfunction

  function automatic logic op_is_store(input logic [3:0] op);
    return (op == OP_ST_HL) || (op == OP_ST_HLUP) || (op == OP_ST_HLDN) ||
           (op == OP_ST_PGC) || (op == OP_ST_PGI);
  endfunction

endpackage

// File: rtl/ldst_regfile.sv
module ldst_regfile
  import ldst_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_we,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [DW-1:0]    byte_wdata,
  input  logic             pair_we,
  input  logic [1:0]       pair_idx,
  input  logic [2*DW-1:0]  pair_wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  input  logic [IDX_W-1:0] obs_idx,
  output logic [DW-1:0]    obs_rd,
  output logic [DW-1:0]    acc,
  output logic [DW-1:0]    reg_c,
  output logic [2*DW-1:0]  hl,
  output logic [2*DW-1:0]  sp
);

  localparam int SLOTS = 2 ** IDX_W;

  logic [DW-1:0]   regs [SLOTS];
  logic [2*DW-1:0] sp_q;

  // one byte write and one pair write per clock; a pair covers slots 2p+1, 2p+2
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) regs[i] <= '0;
      sp_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (pair_we && pair_idx != PAIR_SP && (int'(pair_idx) * 2 + 1) == i)
          regs[i] <= pair_wdata[2*DW-1:DW];
        else if (pair_we && pair_idx != PAIR_SP && (int'(pair_idx) * 2 + 2) == i)
          regs[i] <= pair_wdata[DW-1:0];
        else if (byte_we && int'(byte_idx) == i)
          regs[i] <= byte_wdata;
      end
      if (pair_we && pair_idx == PAIR_SP) sp_q <= pair_wdata;
    end
  end

  assign rd_data = regs[rd_idx];
  assign obs_rd  = regs[obs_idx];
  assign acc     = regs[RSEL_A];
  assign reg_c   = regs[RSEL_C];
  assign hl      = {regs[5], regs[6]};
  assign sp      = sp_q;

endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          AW      = 16,
  parameter logic [7:0]  PAGE_HI = 8'hFF
) (
  input  amode_e          mode,
  input  logic [AW-1:0]   hl,
  input  logic [DW-1:0]   reg_c,
  input  logic [DW-1:0]   imm8,
  output logic [AW-1:0]   addr,
  output logic [AW-1:0]   hl_up,
  output logic [AW-1:0]   hl_dn
);

  localparam int PW = AW - DW;

  always_comb begin
    unique case (mode)
      AM_PAGE_C:   addr = {PW'(PAGE_HI), reg_c};
      AM_PAGE_IMM: addr = {PW'(PAGE_HI), imm8};
      default:     addr = hl;
    endcase
  end

  assign hl_up = hl + AW'(1);
  assign hl_dn = hl - AW'(1);

endmodule

// File: rtl/ldst_sp_offset.sv
module ldst_sp_offset #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic [AW-1:0] sp,
  input  logic [DW-1:0] ofs,
  output logic [AW-1:0] sum,
  output logic          half_cy,
  output logic          byte_cy
);

  localparam int NIB = DW / 2;

  logic [AW-1:0]  ofs_ext;
  logic [NIB:0]   nib_sum;
  logic [DW:0]    low_sum;

  assign ofs_ext = {{(AW - DW){ofs[DW-1]}}, ofs};
  assign sum     = sp + ofs_ext;
  assign nib_sum = {1'b0, sp[NIB-1:0]} + {1'b0, ofs[NIB-1:0]};
  assign low_sum = {1'b0, sp[DW-1:0]} + {1'b0, ofs};
  assign half_cy = nib_sum[NIB];
  assign byte_cy = low_sum[DW];

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int         DW      = 8,
  parameter int         AW      = 16,
  parameter int         MC_CLKS = 4,
  parameter logic [7:0] PAGE_HI = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [2:0]    op_dst,
  input  logic [2:0]    op_src,
  input  logic [7:0]    op_imm8,
  input  logic [15:0]   op_imm16,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [15:0]   mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready,
  output logic [3:0]    flags,
  input  logic [2:0]    obs_sel,
  output logic [7:0]    obs_data
);

  localparam int              CW    = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1;
  localparam logic [CW-1:0]   CLAST = CW'(MC_CLKS - 1);

  seq_e            state;
  logic [CW-1:0]   cnt;
  logic [3:0]      op_q;
  logic [2:0]      dst_q;
  logic [2:0]      src_q;
  logic [DW-1:0]   i8_q;
  logic [AW-1:0]   i16_q;
  logic            got_q;
  logic [DW-1:0]   rbuf_q;
  flags_t          flags_q;
  logic            busy_q;
  logic            done_q;
  logic            req_q;
  logic            we_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [DW-1:0]   obs_q;

  // register file connections
  logic            byte_we;
  logic [2:0]      byte_idx;
  logic [DW-1:0]   byte_wdata;
  logic            pair_we;
  logic [1:0]      pair_idx;
  logic [AW-1:0]   pair_wdata;
  logic [DW-1:0]   src_rd;
  logic [DW-1:0]   obs_rd;
  logic [DW-1:0]   acc;
  logic [DW-1:0]   reg_c;
  logic [AW-1:0]   hl;
  logic [AW-1:0]   sp;

  ldst_regfile #(.DW(DW)) u_rf (
    .clk        (clk),
    .rst        (rst),
    .byte_we    (byte_we),
    .byte_idx   (byte_idx),
    .byte_wdata (byte_wdata),
    .pair_we    (pair_we),
    .pair_idx   (pair_idx),
    .pair_wdata (pair_wdata),
    .rd_idx     (src_q),
    .rd_data    (src_rd),
    .obs_idx    (obs_sel),
    .obs_rd     (obs_rd),
    .acc        (acc),
    .reg_c      (reg_c),
    .hl         (hl),
    .sp         (sp)
  );

  // address selection
  amode_e        amode;
  logic [AW-1:0] ea;
  logic [AW-1:0] hl_up;
  logic [AW-1:0] hl_dn;

  always_comb begin
    if (op_q == OP_LD_PGC || op_q == OP_ST_PGC)      amode = AM_PAGE_C;
    else if (op_q == OP_LD_PGI || op_q == OP_ST_PGI) amode = AM_PAGE_IMM;
    else                                             amode = AM_PAIR;
  end

  ldst_addr_gen #(.DW(DW), .AW(AW), .PAGE_HI(PAGE_HI)) u_ag (
    .mode  (amode),
    .hl    (hl),
    .reg_c (reg_c),
    .imm8  (i8_q),
    .addr  (ea),
    .hl_up (hl_up),
    .hl_dn (hl_dn)
  );

  // stack pointer plus signed offset
  logic [AW-1:0] sp_sum;
  logic          half_cy;
  logic          byte_cy;

  ldst_sp_offset #(.DW(DW), .AW(AW)) u_spo (
    .sp      (sp),
    .ofs     (i8_q),
    .sum     (sp_sum),
    .half_cy (half_cy),
    .byte_cy (byte_cy)
  );

  // completion
  logic          is_mem;
  logic          got_now;
  logic [DW-1:0] rdat;
  logic          commit;

  assign is_mem  = op_is_mem(op_q);
  assign got_now = req_q && mem_ready;
  assign rdat    = got_q ? rbuf_q : mem_rdata;
  assign commit  = ((state == SQ_EXEC) && (cnt == CLAST) && !is_mem) ||
                   ((state == SQ_MEM) && (got_q || got_now) && (cnt == CLAST));

  // write-back decode
  always_comb begin
    byte_we    = 1'b0;
    byte_idx   = RSEL_A;
    byte_wdata = rdat;
    pair_we    = 1'b0;
    pair_idx   = PAIR_HL;
    pair_wdata = hl;
    unique case (op_q)
      OP_MOV: begin
        byte_we    = commit;
        byte_idx   = dst_q;
        byte_wdata = src_rd;
      end
      OP_IMM8: begin
        byte_we    = commit;
        byte_idx   = dst_q;
        byte_wdata = i8_q;
      end
      OP_IMM16: begin
        pair_we    = commit;
        pair_idx   = dst_q[1:0];
        pair_wdata = i16_q;
      end
      OP_LD_HL: begin
        byte_we  = commit;
        byte_idx = dst_q;
      end
      OP_LD_HLUP: begin
        byte_we    = commit;
        pair_we    = commit;
        pair_wdata = hl_up;
      end
      OP_LD_HLDN: begin
        byte_we    = commit;
        pair_we    = commit;
        pair_wdata = hl_dn;
      end
      OP_ST_HLUP: begin
        pair_we    = commit;
        pair_wdata = hl_up;
      end
      OP_ST_HLDN: begin
        pair_we    = commit;
        pair_wdata = hl_dn;
      end
      OP_LD_PGC, OP_LD_PGI: begin
        byte_we = commit;
      end
      OP_SPOFS: begin
        pair_we    = commit;
        pair_wdata = sp_sum;
      end
      default: ;
    endcase
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      op_q    <= '0;
      dst_q   <= '0;
      src_q   <= '0;
      i8_q    <= '0;
      i16_q   <= '0;
      got_q   <= 1'b0;
      rbuf_q  <= '0;
      flags_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      obs_q   <= '0;
    end else begin
      done_q <= commit;
      obs_q  <= obs_rd;
      if (commit && op_q == OP_SPOFS)
        flags_q <= '{z: 1'b0, n: 1'b0, h: half_cy, c: byte_cy};
      unique case (state)
        SQ_IDLE: begin
          if (op_valid) begin
            op_q   <= op_code;
            dst_q  <= op_dst;
            src_q  <= op_src;
            i8_q   <= op_imm8;
            i16_q  <= op_imm16;
            cnt    <= '0;
            busy_q <= 1'b1;
            state  <= SQ_EXEC;
          end
        end
        SQ_EXEC: begin
          if (cnt == CLAST) begin
            cnt <= '0;
            if (is_mem) begin
              state   <= SQ_MEM;
              req_q   <= 1'b1;
              we_q    <= op_is_store(op_q);
              addr_q  <= ea;
              wdata_q <= (op_q == OP_ST_HL) ? src_rd : acc;
              got_q   <= 1'b0;
            end else begin
              state  <= SQ_IDLE;
              busy_q <= 1'b0;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        SQ_MEM: begin
          if (cnt != CLAST) cnt <= cnt + CW'(1);
          if (got_now) begin
            req_q  <= 1'b0;
            we_q   <= 1'b0;
            got_q  <= 1'b1;
            rbuf_q <= mem_rdata;
          end
          if (commit) begin
            state  <= SQ_IDLE;
            busy_q <= 1'b0;
            got_q  <= 1'b0;
            cnt    <= '0;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign flags     = flags_q;
  assign obs_data  = obs_q;

endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        mem_ready,
  input logic [3:0]  flags,
  input logic [3:0]  op_q
);

  // request held steady until accepted
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_req_busy_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_we_req_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

  assert_flags_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(flags) |-> done);

  assert_zn_clear_R8: assert property (@(posedge clk) disable iff (rst)
    flags[3:2] == 2'b00);

  assert_high_page_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req && (op_q >= 4'd9) && (op_q <= 4'd12) |-> mem_addr[15:8] == 8'hFF);

endmodule

bind ldst_unit ldst_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .flags     (flags),
  .op_q      (op_q)
);

// File: tb/tb_ldst_unit.sv
module tb_ldst_unit;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [2:0]  op_dst = '0, op_src = '0;
  logic [7:0]  op_imm8 = '0;
  logic [15:0] op_imm16 = '0;
  logic        busy, done, mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic [3:0]  flags;
  logic [2:0]  obs_sel = '0;
  logic [7:0]  obs_data;

  ldst_unit dut (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0]  mreg [7];
  logic [15:0] msp;
  logic [3:0]  mflags;
  logic [7:0]  mmem [int];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memrd(int a);
    if (mmem.exists(a)) return mmem[a];
    return 8'(a) ^ 8'h3C;
  endfunction

  function automatic logic [15:0] mhl();
    return {mreg[5], mreg[6]};
  endfunction

  task automatic set_hl(logic [15:0] v);
    mreg[5] = v[15:8];
    mreg[6] = v[7:0];
  endtask

  // issue one operation, play memory with 'w' wait cycles, update the model
  task automatic do_op(int code, int dst, int src, int i8, int i16, int w, string req);
    logic [15:0] ea, s;
    logic [7:0]  wd, ld;
    bit          ismem, isst, seen;
    int          n, reqcnt, lat;
    ismem = code >= 3 && code <= 12;
    isst  = code == 4 || code == 7 || code == 8 || code == 10 || code == 12;
    if (code >= 3 && code <= 8) ea = mhl();
    else if (code == 9 || code == 10) ea = {8'hFF, mreg[2]};
    else ea = {8'hFF, 8'(i8)};
    wd  = (code == 4) ? mreg[src] : mreg[0];
    ld  = memrd(int'(ea));
    lat = ismem ? (((5 + w) > 8 ? (5 + w) : 8) + 1) : 5;
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'(code); op_dst = 3'(dst); op_src = 3'(src);
    op_imm8 = 8'(i8); op_imm16 = 16'(i16);
    n = 0; reqcnt = 0; seen = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 1) op_valid = 1'b0;
      if (done) break;
      chk("R9", "flags between completions", int'(flags), int'(mflags));
      if (mem_req) begin
        if (!seen) begin
          seen = 1;
          chk("R10", "request start clock", n, 5);
          chk(req, "address", int'(mem_addr), int'(ea));
          chk(req, "write enable", int'(mem_we), int'(isst));
          if (isst) chk(req, "write data", int'(mem_wdata), int'(wd));
        end
        if (reqcnt >= w) begin
          mem_ready = 1'b1;
          mem_rdata = memrd(int'(mem_addr));
          if (mem_we) mmem[int'(mem_addr)] = mem_wdata;
        end else begin
          mem_ready = 1'b0;
        end
        reqcnt++;
      end else begin
        mem_ready = 1'b0;
      end
      if (n > 60) break;
    end
    mem_ready = 1'b0;
    chk("R10", "done latency", n, lat);
    chk("R10", "memory used", int'(seen), int'(ismem));
    case (code)
      0: mreg[dst] = mreg[src];
      1: mreg[dst] = 8'(i8);
      2: begin
        if (dst == 3) msp = 16'(i16);
        else begin mreg[2*dst+1] = 8'(i16 >> 8); mreg[2*dst+2] = 8'(i16); end
      end
      3: mreg[dst] = ld;
      5: begin mreg[0] = ld; set_hl(mhl() + 16'd1); end
      6: begin mreg[0] = ld; set_hl(mhl() - 16'd1); end
      7: set_hl(mhl() + 16'd1);
      8: set_hl(mhl() - 16'd1);
      9, 11: mreg[0] = ld;
      13: begin
        s = msp + {{8{i8[7]}}, 8'(i8)};
        mflags = {2'b00, ((msp[3:0] + 5'(i8 & 15)) > 15) ? 1'b1 : 1'b0,
                  ((msp[7:0] + 9'(i8 & 255)) > 255) ? 1'b1 : 1'b0};
        set_hl(s);
      end
      default: ;
    endcase
    chk(code == 13 ? "R8" : "R9", "flags at completion", int'(flags), int'(mflags));
    @(negedge clk);
    chk("R10", "done single pulse", int'(done), 0);
  endtask

  task automatic check_regs(string req);
    for (int r = 0; r < 7; r++) begin
      @(negedge clk);
      obs_sel = 3'(r);
      @(negedge clk);
      chk(req, $sformatf("register %0d", r), int'(obs_data), int'(mreg[r]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 7; r++) mreg[r] = '0;
    msp = '0; mflags = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "mem_req", int'(mem_req), 0);
    chk("R1", "mem_we", int'(mem_we), 0);
    chk("R1", "flags", int'(flags), 0);
    check_regs("R1");
    do_op(13, 0, 0, 0, 0, 0, "R1");         // SP+0 -> HL shows reset SP
    check_regs("R1");

    // R3 immediates
    do_op(2, 0, 0, 0, 16'h1234, 0, "R3");
    do_op(2, 1, 0, 0, 16'hABCD, 0, "R3");
    do_op(2, 2, 0, 0, 16'hC0FE, 0, "R3");
    do_op(2, 3, 0, 0, 16'hFFF8, 0, "R3");
    do_op(1, 0, 0, 8'h5A, 0, 0, "R3");
    check_regs("R3");

    // R2 all 49 copies
    for (int r = 0; r < 7; r++) do_op(1, r, 0, 8'h11 * (r + 1), 0, 0, "R3");
    for (int d = 0; d < 7; d++) begin
      for (int s = 0; s < 7; s++) do_op(0, d, s, 0, 0, 0, "R2");
      check_regs("R2");
      for (int r = 0; r < 7; r++) do_op(1, r, 0, 8'h13 * (r + d + 1), 0, 0, "R3");
    end

    // R4 plain pair transfers, varied wait
    do_op(2, 2, 0, 0, 16'hC000, 0, "R3");
    do_op(4, 0, 1, 0, 0, 0, "R4");
    do_op(3, 3, 0, 0, 0, 2, "R4");
    do_op(3, 4, 0, 0, 0, 7, "R4");          // late ready stretches done
    check_regs("R4");

    // R5 step forms with wrap
    do_op(2, 2, 0, 0, 16'hFFFF, 0, "R3");
    do_op(1, 0, 0, 8'hA7, 0, 0, "R3");
    do_op(7, 0, 0, 0, 0, 0, "R5");          // store, HL wraps to 0000
    do_op(6, 0, 0, 0, 0, 1, "R5");          // load from 0000, HL wraps to FFFF
    do_op(5, 0, 0, 0, 0, 3, "R5");          // load from FFFF (written above)
    do_op(8, 0, 0, 0, 0, 5, "R5");
    check_regs("R5");

    // R6 high page
    do_op(1, 2, 0, 8'h80, 0, 0, "R3");
    do_op(1, 0, 0, 8'h42, 0, 0, "R3");
    do_op(10, 0, 0, 0, 0, 0, "R6");
    do_op(1, 0, 0, 8'h00, 0, 0, "R3");
    do_op(9, 0, 0, 0, 0, 1, "R6");
    do_op(12, 0, 0, 8'h05, 0, 0, "R6");
    do_op(11, 0, 0, 8'hFF, 0, 4, "R6");
    check_regs("R6");

    // R7 / R8 stack pointer offset
    do_op(13, 0, 0, 8'h08, 0, 0, "R7");     // FFF8+8 -> 0000, H=1 C=1
    check_regs("R7");
    do_op(13, 0, 0, 8'h00, 0, 0, "R7");     // SP unchanged
    check_regs("R7");
    do_op(2, 3, 0, 0, 16'h1000, 0, "R3");
    do_op(13, 0, 0, 8'hFF, 0, 0, "R7");     // -1 -> 0FFF, flags clear
    check_regs("R7");
    do_op(2, 3, 0, 0, 16'h00FF, 0, "R3");
    do_op(13, 0, 0, 8'h01, 0, 0, "R8");     // 0100, H=1 C=1
    chk("R8", "flags value", int'(flags), 4'b0011);
    do_op(2, 3, 0, 0, 16'h0005, 0, "R3");
    do_op(13, 0, 0, 8'h80, 0, 0, "R7");     // FF85, flags clear
    check_regs("R7");
    do_op(2, 3, 0, 0, 16'h000F, 0, "R3");
    do_op(13, 0, 0, 8'h01, 0, 0, "R8");     // H=1 C=0
    chk("R8", "flags value", int'(flags), 4'b0010);

    // R9 other loads keep flags
    do_op(0, 1, 2, 0, 0, 0, "R9");
    do_op(3, 2, 0, 0, 0, 0, "R9");
    do_op(12, 0, 0, 8'h10, 0, 2, "R9");
    do_op(2, 0, 0, 0, 16'h7777, 0, "R9");
    chk("R9", "flags kept", int'(flags), 4'b0010);

    // R12 undefined codes
    do_op(14, 3, 4, 8'h99, 16'h9999, 0, "R12");
    do_op(15, 5, 6, 8'h99, 16'h9999, 0, "R12");
    check_regs("R12");

    // R11 op_valid while busy is dropped
    do_op(1, 0, 0, 8'h3E, 0, 0, "R3");
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd1; op_dst = 3'd0; op_imm8 = 8'h11;
    @(negedge clk);
    chk("R11", "busy after accept", int'(busy), 1);
    op_imm8 = 8'h22; op_dst = 3'd1;
    repeat (2) @(negedge clk);
    op_valid = 1'b0;
    begin
      int seen_done = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (done) seen_done++;
      end
      chk("R11", "done pulses", seen_done, 1);
    end
    chk("R11", "busy after done", int'(busy), 0);
    mreg[0] = 8'h11;
    check_regs("R11");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule